// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

The block is a general-purpose I/O controller for 32 lines behind a simple word-wide register bus with byte offsets and separate read and write strobes. Software sets each line as input or output, can make an output open-drain, writes output values, and reads back the line state. Pad inputs are brought into the clock domain through a two-flop synchronizer. Each line has an edge detector whose result is latched into a sticky event register. A single interrupt output is raised whenever an enabled line has a pending event.

All registers use reversed bit numbering: line n sits at register bit 31−n. For each line, a control bit selects between falling-edge-only sensing and sensing on any edge. Software clears events by writing ones to them. Reads are registered, so read data appears one clock after the read strobe.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, all six registers read 0, `pad_oe` is all zero and `irq` is low. The byte offsets are: direction 0x00, open-drain 0x04, data 0x08, event 0x0C, mask 0x10, edge control 0x14. An unmapped offset reads 0.
- R2: Line n (index n of `pad_in`, `pad_out` and `pad_oe`) corresponds to bit 31−n of every register.
- R3: A direction bit of 1 makes the line an output. A push-pull output has `pad_oe` 1 and `pad_out` equal to its data bit. An input line has `pad_oe` 0.
- R4: For an output line whose open-drain bit is 1, a data bit of 0 drives `pad_out` 0 with `pad_oe` 1, and a data bit of 1 releases the pad (`pad_oe` 0). `pad_out` is never 1 on an open-drain line.
- R5: A read of the data register returns the synchronized pad value for input lines and the last written data bit for output lines.
- R6: A line whose edge-control bit is 0 latches an event on both rising and falling edges.
- R7: A line whose edge-control bit is 1 latches an event on falling edges only. A rising edge on such a line leaves its event bit 0.
- R8: Writing the event register clears each bit written as 1 and leaves each bit written as 0 unchanged. Event bits are sticky otherwise.
- R9: If an edge and a clear of the same event bit fall in the same cycle, the bit stays set.
- R10: `irq` is high exactly when the AND of the event and mask registers is nonzero. A mask bit of 1 enables its line. Events latch whatever the mask holds.
- R11: A pad change applied before clock edge k sets its event bit, and raises `irq` if that bit is enabled, right after edge k+2. Read data is registered at the edge that samples `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wr | input | 1 | Word write strobe |
| bus_rd | input | 1 | Word read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad input values, index = line |
| pad_out | output | 32 | Pad output values, index = line |
| pad_oe | output | 32 | Pad output enables, index = line |
| irq | output | 1 | Combined interrupt |

## Verification
A pad change made at a falling clock edge passes two synchronizer flops before it reaches the edge comparator. Its event bit, and `irq`, therefore change after the third rising edge. The bench waits four cycles after every pad change before it reads anything, and it samples `irq` at the second and third falling edges to pin down the R11 latency exactly. Register writes take effect at the next rising edge, so `pad_out` and `pad_oe` are compared one falling edge later. Read data is taken at the falling edge that follows the read strobe. The same-cycle clear case drives its clear write so that it lands on the very edge that latches the event.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam logic [7:0] OFF_DIR  = 8'h00;
  localparam logic [7:0] OFF_OD   = 8'h04;
  localparam logic [7:0] OFF_DAT  = 8'h08;
  localparam logic [7:0] OFF_EVT  = 8'h0C;
  localparam logic [7:0] OFF_MSK  = 8'h10;
  localparam logic [7:0] OFF_CTL  = 8'h14;

  // event condition for one line
  function automatic logic edge_hit(input logic cur, input logic prev, input logic fall_only);
    logic fell, moved;
    fell  = prev & ~cur;
    moved = prev ^ cur;
    return fall_only ? fell : moved;
  endfunction

  // output enable for one line
  function automatic logic line_oe(input logic is_out, input logic is_od, input logic val);
    return is_out & ~(is_od & val);
  endfunction

  // driven level for one line
  function automatic logic line_level(input logic is_od, input logic val);
    return val & ~is_od;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_evt.sv
module gpio_edge_evt
  import gpio_edge_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] fall_only,
  input  logic [W-1:0] clr,
  output logic [W-1:0] hit,
  output logic [W-1:0] evt_q
);
  logic [W-1:0] prev_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign hit[b] = edge_hit(smp[b], prev_q[b], fall_only[b]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      evt_q  <= '0;
    end else begin
      prev_q <= smp;
      evt_q  <= (evt_q & ~clr) | hit;
    end
  end
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_edge_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] dir_ln,
  input  logic [W-1:0] od_ln,
  input  logic [W-1:0] dat_ln,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  for (genvar n = 0; n < W; n++) begin : g_line
    assign pad_oe[n]  = line_oe(dir_ln[n], od_ln[n], dat_ln[n]);
    assign pad_out[n] = line_level(od_ln[n], dat_ln[n]);
  end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int LINES       = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [LINES-1:0]  bus_wdata,
  output logic [LINES-1:0]  bus_rdata,
  input  logic [LINES-1:0]  pad_in,
  output logic [LINES-1:0]  pad_out,
  output logic [LINES-1:0]  pad_oe,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_DIR = OFF_DIR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_OD  = OFF_OD[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_DAT = OFF_DAT[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_EVT = OFF_EVT[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_MSK = OFF_MSK[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_CTL = OFF_CTL[ADDR_W-1:0];

  // register-order state (bit LINES-1-n belongs to line n)
  logic [LINES-1:0] dir_q, od_q, dat_q, msk_q, ctl_q;
  logic [LINES-1:0] evt_q, hit_w, evt_clr;
  logic [LINES-1:0] pad_reg_order, pad_sync;
  logic [LINES-1:0] dir_ln, od_ln, dat_ln;
  logic             evt_wr;
  logic [LINES-1:0] rd_mux;

  // line order <-> register order
  for (genvar n = 0; n < LINES; n++) begin : g_map
    assign pad_reg_order[LINES-1-n] = pad_in[n];
    assign dir_ln[n] = dir_q[LINES-1-n];
    assign od_ln[n]  = od_q[LINES-1-n];
    assign dat_ln[n] = dat_q[LINES-1-n];
  end

  gpio_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_reg_order),
    .q     (pad_sync)
  );

  assign evt_wr  = bus_wr && (bus_addr == A_EVT);
  assign evt_clr = evt_wr ? bus_wdata : '0;

  gpio_edge_evt #(.W(LINES)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp       (pad_sync),
    .fall_only (ctl_q),
    .clr       (evt_clr),
    .hit       (hit_w),
    .evt_q     (evt_q)
  );

  gpio_pad_drive #(.W(LINES)) u_drive (
    .dir_ln  (dir_ln),
    .od_ln   (od_ln),
    .dat_ln  (dat_ln),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      od_q  <= '0;
      dat_q <= '0;
      msk_q <= '0;
      ctl_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_DIR) dir_q <= bus_wdata;
      if (bus_addr == A_OD)  od_q  <= bus_wdata;
      if (bus_addr == A_DAT) dat_q <= bus_wdata;
      if (bus_addr == A_MSK) msk_q <= bus_wdata;
      if (bus_addr == A_CTL) ctl_q <= bus_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      A_DIR:   rd_mux = dir_q;
      A_OD:    rd_mux = od_q;
      A_DAT:   rd_mux = (dat_q & dir_q) | (pad_sync & ~dir_q);
      A_EVT:   rd_mux = evt_q;
      A_MSK:   rd_mux = msk_q;
      A_CTL:   rd_mux = ctl_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign irq = |(evt_q & msk_q);
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
  parameter int LINES = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_wr,
  input logic [LINES-1:0] evt_q,
  input logic [LINES-1:0] msk_q,
  input logic [LINES-1:0] hit_w,
  input logic [LINES-1:0] dir_ln,
  input logic [LINES-1:0] od_ln,
  input logic [LINES-1:0] pad_out,
  input logic [LINES-1:0] pad_oe,
  input logic             irq
);
  // R3
  in_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_ln == '0) |-> (pad_oe == '0));

  // R4
  od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & od_ln) == '0));

  // R8
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_wr |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  // R6
  evt_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & ~$past(evt_q) & ~$past(hit_w)) == '0));

  // R9
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(hit_w) & ~evt_q) == '0));

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == '0) |-> !irq);

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evt_q != '0));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.LINES(LINES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .evt_wr  (evt_wr),
  .evt_q   (evt_q),
  .msk_q   (msk_q),
  .hit_w   (hit_w),
  .dir_ln  (dir_ln),
  .od_ln   (od_ln),
  .pad_out (pad_out),
  .pad_oe  (pad_oe),
  .irq     (irq)
);

// File: tb/tb_gpio_edge_ctrl.sv
module tb_gpio_edge_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench model, register order
  logic [31:0] m_dir = '0, m_od = '0, m_dat = '0, m_msk = '0, m_ctl = '0, m_evt = '0;

  localparam logic [4:0] A_DIR = 5'h00, A_OD = 5'h04, A_DAT = 5'h08,
                         A_EVT = 5'h0C, A_MSK = 5'h10, A_CTL = 5'h14;

  always #5 clk = ~clk;

  gpio_edge_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  function automatic logic [31:0] flip(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  // events caused by a pad move, register order
  function automatic logic [31:0] exp_hit(input logic [31:0] oldp, input logic [31:0] newp,
                                          input logic [31:0] ctl);
    logic [31:0] o, n;
    o = flip(oldp);
    n = flip(newp);
    return (ctl & (o & ~n)) | (~ctl & (o ^ n));
  endfunction

  function automatic logic [31:0] exp_data();
    return (m_dat & m_dir) | (flip(pad_in) & ~m_dir);
  endfunction

  function automatic logic [31:0] exp_oe();
    return flip(m_dir & ~(m_od & m_dat));
  endfunction

  function automatic logic [31:0] exp_out();
    return flip(m_dat & ~m_od);
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      A_DIR: m_dir = d;
      A_OD:  m_od  = d;
      A_DAT: m_dat = d;
      A_MSK: m_msk = d;
      A_CTL: m_ctl = d;
      A_EVT: m_evt = m_evt & ~d;
      default: ;
    endcase
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic move_pad(input logic [31:0] np);
    m_evt = m_evt | exp_hit(pad_in, np, m_ctl);
    pad_in = np;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_pads(input string tag);
    check(pad_oe == exp_oe(), tag, pad_oe, exp_oe());
    check(pad_out == exp_out(), tag, pad_out, exp_out());
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and offsets
    begin
      logic [4:0] addrs [7] = '{A_DIR, A_OD, A_DAT, A_EVT, A_MSK, A_CTL, 5'h1C};
      foreach (addrs[i]) begin
        bus_read(addrs[i], rd);
        check(rd == 32'h0, "R1 reset read", rd, 32'h0);
      end
    end
    check(pad_oe == 32'h0, "R1 reset oe", pad_oe, 32'h0);
    check({31'h0, irq} == 32'h0, "R1 reset irq", {31'h0, irq}, 32'h0);

    // R2 R3 line 0 is register bit 31
    bus_write(A_DAT, 32'h8000_0000);
    bus_write(A_DIR, 32'h8000_0000);
    check(pad_oe == 32'h0000_0001, "R2 line0 oe", pad_oe, 32'h1);
    check(pad_out == 32'h0000_0001, "R2 R3 line0 out", pad_out, 32'h1);
    bus_read(A_DIR, rd);
    check(rd == 32'h8000_0000, "R1 dir readback", rd, 32'h8000_0000);

    // R4 open-drain on line 0
    bus_write(A_OD, 32'h8000_0000);
    check(pad_oe == 32'h0 && pad_out == 32'h0, "R4 od release", pad_oe, 32'h0);
    bus_write(A_DAT, 32'h0);
    check(pad_oe == 32'h1 && pad_out == 32'h0, "R4 od drive low", pad_oe, 32'h1);
    bus_write(A_OD, 32'h0);
    bus_write(A_DIR, 32'h0);

    // R5 data read: input line shows pad, output line shows written bit
    pad_in = 32'h0000_0003;  // lines 0 and 1 high
    m_evt = m_evt | exp_hit(32'h0, 32'h3, m_ctl);
    repeat (4) @(negedge clk);
    bus_write(A_DIR, 32'h4000_0000);  // line 1 output, data 0
    bus_read(A_DAT, rd);
    check(rd == 32'h8000_0000, "R5 data mix", rd, 32'h8000_0000);
    bus_write(A_DIR, 32'h0);
    bus_write(A_EVT, 32'hFFFF_FFFF);
    move_pad(32'h0);
    bus_write(A_EVT, 32'hFFFF_FFFF);

    // R6 any-edge on line 5 (bit 26)
    move_pad(32'h0000_0020);
    bus_read(A_EVT, rd);
    check(rd == 32'h0400_0000, "R6 rise event", rd, 32'h0400_0000);
    // R8 writing 0 keeps, writing 1 clears
    bus_write(A_EVT, 32'h0);
    bus_read(A_EVT, rd);
    check(rd == 32'h0400_0000, "R8 zero write keeps", rd, 32'h0400_0000);
    bus_write(A_EVT, 32'h0400_0000);
    bus_read(A_EVT, rd);
    check(rd == 32'h0, "R8 one write clears", rd, 32'h0);
    move_pad(32'h0);
    bus_read(A_EVT, rd);
    check(rd == 32'h0400_0000, "R6 fall event", rd, 32'h0400_0000);
    bus_write(A_EVT, 32'hFFFF_FFFF);

    // R7 falling-only on line 6 (bit 25)
    bus_write(A_CTL, 32'h0200_0000);
    move_pad(32'h0000_0040);
    bus_read(A_EVT, rd);
    check(rd == 32'h0, "R7 rise ignored", rd, 32'h0);
    move_pad(32'h0);
    bus_read(A_EVT, rd);
    check(rd == 32'h0200_0000, "R7 fall event", rd, 32'h0200_0000);

    // R10 mask gates irq only
    check({31'h0, irq} == 32'h0, "R10 masked irq", {31'h0, irq}, 32'h0);
    bus_write(A_MSK, 32'h0200_0000);
    check({31'h0, irq} == 32'h1, "R10 enabled irq", {31'h0, irq}, 32'h1);
    bus_write(A_MSK, 32'h0100_0000);
    check({31'h0, irq} == 32'h0, "R10 other line mask", {31'h0, irq}, 32'h0);
    bus_write(A_CTL, 32'h0);
    bus_write(A_EVT, 32'hFFFF_FFFF);

    // R11 latency: line 7 (bit 24) enabled, change at negedge N0
    pad_in = 32'h0000_0080;
    m_evt = m_evt | 32'h0100_0000;
    @(negedge clk); @(negedge clk);
    check({31'h0, irq} == 32'h0, "R11 not yet", {31'h0, irq}, 32'h0);
    @(negedge clk);
    check({31'h0, irq} == 32'h1, "R11 due edge", {31'h0, irq}, 32'h1);

    // R9 collision: bit 24 is set; its next edge meets a clear write
    pad_in = 32'h0;
    @(negedge clk); @(negedge clk);
    bus_write(A_EVT, 32'h0100_0000);
    m_evt = m_evt | 32'h0100_0000;
    bus_read(A_EVT, rd);
    check(rd == 32'h0100_0000, "R9 edge wins", rd, 32'h0100_0000);
    bus_write(A_EVT, 32'hFFFF_FFFF);
    bus_write(A_MSK, 32'h0);

    // random mix
    for (int it = 0; it < 60; it++) begin
      bus_write(A_DIR, $urandom);
      bus_write(A_OD, $urandom);
      bus_write(A_DAT, $urandom);
      bus_write(A_CTL, $urandom);
      bus_write(A_MSK, $urandom);
      check_pads("R3 R4 random pads");
      move_pad($urandom);
      bus_read(A_EVT, rd);
      check(rd == m_evt, "R6 R7 random events", rd, m_evt);
      check({31'h0, irq} == {31'h0, |(m_evt & m_msk)}, "R10 random irq",
            {31'h0, irq}, {31'h0, |(m_evt & m_msk)});
      bus_read(A_DAT, rd);
      check(rd == exp_data(), "R5 random data", rd, exp_data());
      bus_write(A_EVT, $urandom);
      bus_read(A_EVT, rd);
      check(rd == m_evt, "R8 random clear", rd, m_evt);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule